// File: doc/BRIEF.md
# Link-Enable Control Register File

This block is the software-visible control word store of a serial service-bus master. A host reaches it over a simple synchronous bus with a byte address, write data, a write strobe and a read strobe. The word index is the byte address shifted right by two. Most indices are plain 32-bit storage words. The last valid index is the one at byte offset 0x2E0.

Two words are special: they enable downstream links 0–31 (low word) and 32–63 (high word). Both are driven out continuously on a 64-bit enable vector. Software can change each enable word in three ways: load it whole, OR ones into it through a set alias, or knock bits out of it through a clear alias. Software can therefore change one link without a read-modify-write.

A bank-reset word can wipe the whole file in one write. Accesses beyond the last index are dropped silently.

Top module: `svc_port_ctrl_regs`

## Requirements
- R1: After reset every in-range word reads zero and `port_en_o` is all zeros.
- R2: A write to byte offset 0x010 loads the low enable word and a write to 0x014 loads the high enable word. `port_en_o[31:0]` shows the low word and `port_en_o[63:32]` shows the high word. Reads of 0x010 and 0x014 return the enable words.
- R3: A write to 0x018 ORs the write data into the low enable word, and a write to 0x01C does the same for the high enable word.
- R4: A write to 0x020 clears the low enable bits where the write data is one, and a write to 0x024 does the same for the high enable word.
- R5: An access whose word index is 185 or more (byte offset 0x2E4 and up) is ignored. A read there returns zero, and a write there changes no word and no enable bit.
- R6: A write to any other in-range index stores the data, and a later read of that index returns it. This includes the last index, at offset 0x2E0.
- R7: Reading a set or clear alias offset (0x018, 0x01C, 0x020, 0x024) returns that index's own word, which is always zero. Alias writes never land there.
- R8: A write to the link-reset word at 0x0D0 leaves it reading zero, whatever the data, and does not change the enable words.
- R9: A write to the bank-reset word at 0x1D0 with data bit 31 set clears every word and both enable words. (Bit 31 is bit 0 in big-endian numbering.) Every word reads zero from the next cycle on. A write there with bit 31 clear stores the data like a plain word, even when bit 30 (the error-reset bit) is set.
- R10: Read data appears on `rdata_o` in the cycle after `re_i` is sampled high and holds while `re_i` stays low. Address bits 1:0 are ignored.
- R11: When a read and a write hit the same index in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, acts on the rising edge |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| port_en_o | output | 64 | Link enables, links 63..0 |

## Verification
A wrong enable bit shows on `port_en_o` at the first sample after the write edge. The bench compares the full 64-bit vector after every enable, alias, out-of-range and reset write. A corrupted storage word, or a mis-decoded alias, stays hidden until that index is read back. The read-back then shows the mismatch one cycle after the strobe. For that reason every alias offset, boundary index and reset word is read explicitly, and the scoreboard pairs each read strobe with its expected word.

// File: rtl/svc_regs_pkg.sv
package svc_regs_pkg;

  // Word indices whose behaviour differs from plain storage.
  localparam int unsigned IDX_EN_LO    = 4;    // byte 0x010
  localparam int unsigned IDX_EN_HI    = 5;    // byte 0x014
  localparam int unsigned IDX_SET_LO   = 6;    // byte 0x018
  localparam int unsigned IDX_SET_HI   = 7;    // byte 0x01C
  localparam int unsigned IDX_CLR_LO   = 8;    // byte 0x020
  localparam int unsigned IDX_CLR_HI   = 9;    // byte 0x024
  localparam int unsigned IDX_LINK_RST = 52;   // byte 0x0D0
  localparam int unsigned IDX_BANK_RST = 116;  // byte 0x1D0

  // Big-endian bit number of the general-reset flag in the bank-reset word.
  localparam int unsigned GEN_RST_BE_BIT = 0;

  // Big-endian bit number to little-endian position.
  function automatic int unsigned be_to_le(input int unsigned be_bit,
                                           input int unsigned width);
    return width - 1 - be_bit;
  endfunction

  // Indices that never hold written data (enables, aliases, link reset).
  function automatic logic is_no_store(input int unsigned idx);
    return (idx >= IDX_EN_LO && idx <= IDX_CLR_HI) || (idx == IDX_LINK_RST);
  endfunction

  typedef struct packed {
    logic       in_range;
    logic       plain;
    logic [1:0] dir;
    logic [1:0] set;
    logic [1:0] clr;
    logic       bank_rst;
  } hit_t;

endpackage

// File: rtl/svc_rst_sync.sv
module svc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/svc_reg_decode.sv
module svc_reg_decode
  import svc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 185,
  parameter int unsigned IDX_W    = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output hit_t              hit_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              no_store;

  always_comb begin
    word            = addr_i[ADDR_W-1:2];
    hit_o.in_range  = (word < WORD_W'(NUM_REGS));
    hit_o.dir[0]    = hit_o.in_range && (word == WORD_W'(IDX_EN_LO));
    hit_o.dir[1]    = hit_o.in_range && (word == WORD_W'(IDX_EN_HI));
    hit_o.set[0]    = hit_o.in_range && (word == WORD_W'(IDX_SET_LO));
    hit_o.set[1]    = hit_o.in_range && (word == WORD_W'(IDX_SET_HI));
    hit_o.clr[0]    = hit_o.in_range && (word == WORD_W'(IDX_CLR_LO));
    hit_o.clr[1]    = hit_o.in_range && (word == WORD_W'(IDX_CLR_HI));
    hit_o.bank_rst  = hit_o.in_range && (word == WORD_W'(IDX_BANK_RST));
    no_store        = (|hit_o.dir) || (|hit_o.set) || (|hit_o.clr) ||
                      (word == WORD_W'(IDX_LINK_RST));
    hit_o.plain     = hit_o.in_range && !no_store;
    idx_o           = word[IDX_W-1:0];
  end
endmodule

// File: rtl/svc_en_word.sv
module svc_en_word #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic         wr_dir_i,
  input  logic         wr_set_i,
  input  logic         wr_clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = clr_all_i | wr_dir_i | wr_set_i | wr_clr_i;
    q_d  = q_q;
    if (clr_all_i)     q_d = '0;
    else if (wr_dir_i) q_d = wdata_i;
    else if (wr_set_i) q_d = q_q | wdata_i;
    else if (wr_clr_i) q_d = q_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;

  a_r2_direct_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_i |=> (q_o == $past(wdata_i)));
  a_r3_set_ors_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set_i && !clr_all_i) |=> (q_o == ($past(q_o) | $past(wdata_i))));
  a_r4_clear_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr_i && !clr_all_i) |=> (q_o == ($past(q_o) & ~$past(wdata_i))));
  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_all_i || wr_dir_i || wr_set_i || wr_clr_i) |=> $stable(q_o));
endmodule

// File: rtl/svc_word_bank.sv
module svc_word_bank
  import svc_regs_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned NUM_REGS = 185,
  parameter int unsigned IDX_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_all_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [W-1:0]     en_lo_i,
  input  logic [W-1:0]     en_hi_i,
  output logic [W-1:0]     rd_word_o
);
  logic [W-1:0] words [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    if (is_no_store(i)) begin : g_const
      assign words[i] = '0;
    end else begin : g_store
      logic [W-1:0] w_q;
      logic [W-1:0] w_d;
      logic         w_en;
      always_comb begin
        w_en = clr_all_i | (wr_en_i && (wr_idx_i == IDX_W'(i)));
        w_d  = clr_all_i ? '0 : wdata_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   w_q <= '0;
        else if (w_en) w_q <= w_d;
      end
      assign words[i] = w_q;
    end
  end

  always_comb begin
    if (rd_idx_i == IDX_W'(IDX_EN_LO))      rd_word_o = en_lo_i;
    else if (rd_idx_i == IDX_W'(IDX_EN_HI)) rd_word_o = en_hi_i;
    else if (rd_idx_i < IDX_W'(NUM_REGS))   rd_word_o = words[rd_idx_i];
    else                                    rd_word_o = '0;
  end
endmodule

// File: rtl/svc_port_ctrl_regs.sv
module svc_port_ctrl_regs
  import svc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LAST_OFF = 32'h2E0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                we_i,
  input  logic                re_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [2*DATA_W-1:0] port_en_o
);
  localparam int unsigned NUM_REGS  = (LAST_OFF >> 2) + 1;
  localparam int unsigned IDX_W     = $clog2(NUM_REGS);
  localparam int unsigned GEN_RST_B = be_to_le(GEN_RST_BE_BIT, DATA_W);

  logic              rst_n;
  logic [IDX_W-1:0]  idx;
  hit_t              hits;
  logic              clr_all;
  logic [DATA_W-1:0] en_word [2];
  logic [DATA_W-1:0] bank_word;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  svc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  svc_reg_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_decode (
    .addr_i (addr_i),
    .idx_o  (idx),
    .hit_o  (hits)
  );

  assign clr_all = we_i && hits.bank_rst && wdata_i[GEN_RST_B];

  for (genvar h = 0; h < 2; h++) begin : g_en
    svc_en_word #(.W(DATA_W)) u_en (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .clr_all_i (clr_all),
      .wr_dir_i  (we_i && hits.dir[h]),
      .wr_set_i  (we_i && hits.set[h]),
      .wr_clr_i  (we_i && hits.clr[h]),
      .wdata_i   (wdata_i),
      .q_o       (en_word[h])
    );
    assign port_en_o[h*DATA_W +: DATA_W] = en_word[h];
  end

  svc_word_bank #(
    .W        (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .clr_all_i (clr_all),
    .wr_en_i   (we_i && hits.plain),
    .wr_idx_i  (idx),
    .wdata_i   (wdata_i),
    .rd_idx_i  (idx),
    .en_lo_i   (en_word[0]),
    .en_hi_i   (en_word[1]),
    .rd_word_o (bank_word)
  );

  always_comb begin
    rdata_d = hits.in_range ? bank_word : '0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (re_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  a_r5_oor_read_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (re_i && !hits.in_range) |=> (rdata_o == '0));
  a_r5_oor_write_keeps_en: assert property (@(posedge clk_i) disable iff (!rst_n)
    (we_i && !hits.in_range) |=> $stable(port_en_o));
  a_r9_bank_clear: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr_all |=> (port_en_o == '0));
  a_r10_read_holds: assert property (@(posedge clk_i) disable iff (!rst_n)
    !re_i |=> $stable(rdata_o));
endmodule

// File: tb/svc_port_ctrl_regs_bench.sv
module svc_port_ctrl_regs_bench;
  localparam int unsigned NREG = 185;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic [63:0] port_en;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] m_mem [NREG];
  logic [31:0] m_lo;
  logic [31:0] m_hi;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  svc_port_ctrl_regs u_svc_port_ctrl_regs (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .we_i      (we),
    .re_i      (re),
    .rdata_o   (rdata),
    .port_en_o (port_en)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int unsigned w = int'(a >> 2);
    if (w >= NREG) return '0;
    if (w == 4) return m_lo;
    if (w == 5) return m_hi;
    return m_mem[w];
  endfunction

  function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
    int unsigned w = int'(a >> 2);
    if (w >= NREG) return;
    case (w)
      4: m_lo = d;
      5: m_hi = d;
      6: m_lo = m_lo | d;
      7: m_hi = m_hi | d;
      8: m_lo = m_lo & ~d;
      9: m_hi = m_hi & ~d;
      52: ;
      116: begin
        if (d[31]) begin
          for (int i = 0; i < NREG; i++) m_mem[i] = '0;
          m_lo = '0;
          m_hi = '0;
        end else m_mem[w] = d;
      end
      default: m_mem[w] = d;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    re = 1'b1; addr = a;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  // Read and write of one index in the same cycle.
  task automatic rd_wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    re = 1'b1; we = 1'b1; addr = a; wdata = d;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0; we = 1'b0;
    model_write(a, d);
  endtask

  task automatic check_en(input string tag);
    check(tag, port_en, {m_hi, m_lo});
  endtask

  // Monitor: pair every sampled read strobe with the oldest expectation.
  always @(posedge clk) rd_seen <= re;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10: got %h expected nothing queued", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, {32'h0, rdata}, {32'h0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) m_mem[i] = '0;
    m_lo = '0;
    m_hi = '0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_en("R1 enables after reset");
    rd(12'h010, "R1 low enable");
    rd(12'h014, "R1 high enable");
    rd(12'h2E0, "R1 last word");
    rd(12'h1D0, "R1 bank reset word");

    // R2 direct loads
    wr(12'h010, 32'hA5A5_0F0F);
    check_en("R2 low direct");
    wr(12'h014, 32'h1234_5678);
    check_en("R2 high direct");
    rd(12'h010, "R2 read low");
    rd(12'h014, "R2 read high");

    // R3 set aliases
    wr(12'h018, 32'h0000_F0F0);
    check_en("R3 low set");
    wr(12'h01C, 32'h8000_0001);
    check_en("R3 high set");

    // R4 clear aliases
    wr(12'h020, 32'h0000_0F00);
    check_en("R4 low clear");
    wr(12'h024, 32'hFFFF_0000);
    check_en("R4 high clear");
    rd(12'h010, "R4 read low");

    // R7 alias offsets read their own zero word
    rd(12'h018, "R7 set low alias");
    rd(12'h01C, "R7 set high alias");
    rd(12'h020, "R7 clear low alias");
    rd(12'h024, "R7 clear high alias");

    // R6 plain storage incl. last index
    wr(12'h040, 32'hDEAD_BEEF);
    wr(12'h2E0, 32'hCAFE_F00D);
    wr(12'h000, 32'h0000_0011);
    rd(12'h040, "R6 word 0x040");
    rd(12'h2E0, "R6 last word");
    rd(12'h000, "R6 word 0");
    rd(12'h2DC, "R6 neighbour untouched");

    // R5 out of range
    wr(12'h2E4, 32'h1111_1111);
    wr(12'hFFC, 32'h2222_2222);
    wr(12'h2F0, 32'hFFFF_FFFF);
    check_en("R5 enables after out-of-range writes");
    rd(12'h2E4, "R5 read first out-of-range");
    rd(12'hFFC, "R5 read top address");
    rd(12'h2E0, "R5 last word kept");

    // R8 link reset word
    wr(12'h0D0, 32'hFFFF_FFFF);
    rd(12'h0D0, "R8 link reset reads zero");
    check_en("R8 enables kept");

    // R10 low address bits ignored, data holds
    rd(12'h013, "R10 low bits ignored");
    repeat (3) @(negedge clk);
    check("R10 hold while idle", {32'h0, rdata}, {32'h0, model_read(12'h010)});

    // R11 same-cycle read and write
    rd_wr(12'h040, 32'h0BAD_F00D, "R11 read sees old value");
    rd(12'h040, "R11 new value after");

    // R9 bank reset word
    wr(12'h1D0, 32'h0000_1234);
    rd(12'h1D0, "R9 stored without general bit");
    wr(12'h1D0, 32'h4000_0000);
    check_en("R9 error bit keeps enables");
    rd(12'h1D0, "R9 error bit stored");
    wr(12'h1D0, 32'h8000_0000);
    check_en("R9 general reset clears enables");
    rd(12'h040, "R9 word cleared");
    rd(12'h2E0, "R9 last word cleared");
    rd(12'h1D0, "R9 reset word cleared");
    rd(12'h000, "R9 word 0 cleared");

    // R3 set from a cleared state
    wr(12'h018, 32'h0000_0001);
    check_en("R3 set after clear");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule